// File: doc/BRIEF.md
# Byte-Wide Pin Control Register Bank with Interrupt Lines

This block gives software one byte per general-purpose pin behind a small byte-access bus window. Each pin byte carries a driven value, an enable that makes the pin drive, and a sampled input value. When a pin drives, whatever software writes as the driven value is echoed into the sampled bit, so a read sees the pin's own output. Pins that do not drive take their sampled bit from per-pin update strobes supplied by the pad logic around the block.

Two pins feed interrupt lines whose polarity is fixed in hardware. One is a level line that is active while its pin reads low. The other follows its pin and is normally pulsed by a non-maskable request input, which drives the pin high for one cycle and then low again. An interrupt line moves only when an input update really changes the sampled bit. A bus write that rewrites the sampled bit leaves the lines where they are. A separate sticky flag records any input update made to a pin that is currently driving.

Top module: `gpio_regblock`

## Requirements
- R1: After reset every pin byte reads 0x00, except pin 1, which reads 0x02 (sampled bit set). All interrupt outputs are low and the misuse flag is low.
- R2: In a pin byte, bit 0 is the driven value, bit 1 is the sampled input and bit 2 is the drive enable. Bits 7..3 are stored as written. A write discards the written bit 1. If the written bit 2 is 1, the stored bit 1 becomes the written bit 0. If it is 0, the stored bit 1 keeps its old value.
- R3: Bus offsets 0..7 form a level bank that reads 0x00. Writes to it change no pin byte.
- R4: Bus offset 8+p selects the byte of pin p, for p from 0 to 35.
- R5: Offsets 44..63 read 0x00, and writes there change no pin byte.
- R6: An input update replaces only bit 1 of its pin byte. If bit 1 already holds the new value, no interrupt output moves.
- R7: Interrupt output 1 is set by an update that takes pin 1's sampled bit from 1 to 0. It is cleared by an update that takes it from 0 to 1.
- R8: Interrupt output 9 is set by an update that takes pin 9's sampled bit from 0 to 1. It is cleared by an update that takes it from 1 to 0.
- R9: A one-cycle NMI request drives pin 9's sampled bit high in the next cycle and low in the cycle after. Interrupt output 9 is then high for exactly one cycle, and pin 9's byte ends with bit 1 clear.
- R10: Interrupt outputs other than 1 and 9 stay low whatever the inputs do.
- R11: An input update to a pin whose drive enable is set is still applied. It sets the misuse flag, which stays set until reset.
- R12: A bus write that changes a sampled bit does not move any interrupt output.
- R13: When a bus write and an input update hit the same pin in one cycle, the write is applied first and the update then sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one byte per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of a read access |
| pin_upd | input | 36 | Per-pin input update strobe |
| pin_val | input | 36 | New sampled value for each strobed pin |
| nmi_req | input | 1 | Non-maskable pulse request |
| irq_out | output | 10 | Interrupt lines, one per low-numbered pin |
| misuse_flag | output | 1 | Sticky: input update seen on a driving pin |

## Verification
The assertions assume that reset is applied before any other stimulus. They also assume that the NMI request and the pin 9 update strobe name a cause in the cycle before interrupt line 9 rises, so any rise of that line must trace back to one of them. The bench presents at most one bus access per cycle, on a whole clock period. It changes strobes only on the falling edge and raises the NMI request for single cycles, so each update is seen exactly once by the design and by the bench model. It sweeps every byte value into every pin and every offset of the address space. The sampled bit of pins 1 and 9 is preset through bus writes before the update strobes are applied, so both the interrupt-moving and the no-change cases are covered.

// File: rtl/gpio_regblock_pkg.sv
package gpio_regblock_pkg;

    typedef struct packed {
        logic [4:0] spare;
        logic       drv_en;
        logic       sampled;
        logic       drv_val;
    } pin_byte_t;

    typedef enum logic [1:0] {
        WIN_LEVEL = 2'd0,
        WIN_PIN   = 2'd1,
        WIN_NONE  = 2'd2
    } win_kind_e;

    typedef enum logic [1:0] {
        IRQ_NONE      = 2'd0,
        IRQ_LOW_LEVEL = 2'd1,
        IRQ_FOLLOW    = 2'd2
    } irq_mode_e;

    typedef enum logic {
        NMI_IDLE = 1'b0,
        NMI_DROP = 1'b1
    } nmi_phase_e;

    function automatic pin_byte_t apply_bus_write(pin_byte_t cur, logic [7:0] wd);
        pin_byte_t nxt;
        nxt = pin_byte_t'(wd);
        nxt.sampled = nxt.drv_en ? nxt.drv_val : cur.sampled;
        return nxt;
    endfunction

    function automatic pin_byte_t apply_input(pin_byte_t cur, logic v);
        pin_byte_t nxt;
        nxt = cur;
        nxt.sampled = v;
        return nxt;
    endfunction

    function automatic irq_mode_e mode_for_pin(int pin, int lvl_pin, int pls_pin, int n_irq);
        if (pin >= n_irq)        return IRQ_NONE;
        else if (pin == lvl_pin) return IRQ_LOW_LEVEL;
        else if (pin == pls_pin) return IRQ_FOLLOW;
        else                     return IRQ_NONE;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regblock_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LEVEL_BYTES = 8,
    parameter int NUM_PINS    = 36,
    localparam int IDX_W      = ADDR_W
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output win_kind_e           kind,
    output logic [IDX_W-1:0]    pin_idx,
    output logic [NUM_PINS-1:0] wr_hit
);
    localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(LEVEL_BYTES);
    localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(LEVEL_BYTES + NUM_PINS);

    always_comb begin
        pin_idx = bus_addr - PIN_BASE;
        if (bus_addr < PIN_BASE)     kind = WIN_LEVEL;
        else if (bus_addr < PIN_END) kind = WIN_PIN;
        else                         kind = WIN_NONE;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_hit
        assign wr_hit[p] = bus_sel && bus_wr && (kind == WIN_PIN)
                           && (pin_idx == IDX_W'(p));
    end

endmodule

// File: rtl/gpio_nmi_seq.sv
module gpio_nmi_seq
    import gpio_regblock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    output logic drive_en,
    output logic drive_val
);
    nmi_phase_e phase_q;

    always_comb begin
        drive_en  = (phase_q == NMI_DROP) || nmi_req;
        drive_val = (phase_q == NMI_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= NMI_IDLE;
        end else if (phase_q == NMI_DROP) begin
            phase_q <= NMI_IDLE;
        end else if (nmi_req) begin
            phase_q <= NMI_DROP;
        end
    end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_regblock_pkg::*;
#(
    parameter irq_mode_e IRQ_MODE = IRQ_NONE,
    parameter bit        RST_IN   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       upd_en,
    input  logic       upd_val,
    output pin_byte_t  byte_q,
    output logic       misuse,
    output logic       irq
);
    pin_byte_t after_wr;
    pin_byte_t after_upd;

    always_comb begin
        after_wr  = wr_en  ? apply_bus_write(byte_q, wdata) : byte_q;
        after_upd = upd_en ? apply_input(after_wr, upd_val) : after_wr;
        misuse    = upd_en && after_wr.drv_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= pin_byte_t'({5'b0, 1'b0, RST_IN, 1'b0});
        end else begin
            byte_q <= after_upd;
        end
    end

    if (IRQ_MODE == IRQ_NONE) begin : g_no_irq
        assign irq = 1'b0;
    end else begin : g_irq
        logic changed;
        logic irq_q;
        assign changed = upd_en && (after_upd.sampled != after_wr.sampled);
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q <= 1'b0;
            end else if (changed) begin
                irq_q <= (IRQ_MODE == IRQ_LOW_LEVEL) ? !after_upd.sampled
                                                     : after_upd.sampled;
            end
        end
        assign irq = irq_q;
    end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
    import gpio_regblock_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LEVEL_BYTES = 8,
    parameter int NUM_PINS    = 36,
    parameter int NUM_IRQ     = 10,
    parameter int LVL_PIN     = 1,
    parameter int PULSE_PIN   = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pin_upd,
    input  logic [NUM_PINS-1:0] pin_val,
    input  logic                nmi_req,
    output logic [NUM_IRQ-1:0]  irq_out,
    output logic                misuse_flag
);
    localparam int IDX_W = ADDR_W;

    win_kind_e             kind;
    logic [IDX_W-1:0]      pin_idx;
    logic [NUM_PINS-1:0]   wr_hit;
    logic [NUM_PINS-1:0]   misuse_v;
    logic [NUM_PINS-1:0]   cell_irq;
    pin_byte_t             bytes [NUM_PINS];
    logic                  nmi_drive_en;
    logic                  nmi_drive_val;
    logic                  misuse_q;

    gpio_addr_decode #(
        .ADDR_W      (ADDR_W),
        .LEVEL_BYTES (LEVEL_BYTES),
        .NUM_PINS    (NUM_PINS)
    ) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .kind     (kind),
        .pin_idx  (pin_idx),
        .wr_hit   (wr_hit)
    );

    gpio_nmi_seq u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_req   (nmi_req),
        .drive_en  (nmi_drive_en),
        .drive_val (nmi_drive_val)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic upd_en;
        logic upd_val;
        if (p == PULSE_PIN) begin : g_nmi_mux
            assign upd_en  = pin_upd[p] || nmi_drive_en;
            assign upd_val = nmi_drive_en ? nmi_drive_val : pin_val[p];
        end else begin : g_direct
            assign upd_en  = pin_upd[p];
            assign upd_val = pin_val[p];
        end

        gpio_pin_cell #(
            .IRQ_MODE (mode_for_pin(p, LVL_PIN, PULSE_PIN, NUM_IRQ)),
            .RST_IN   (p == LVL_PIN)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_hit[p]),
            .wdata   (bus_wdata),
            .upd_en  (upd_en),
            .upd_val (upd_val),
            .byte_q  (bytes[p]),
            .misuse  (misuse_v[p]),
            .irq     (cell_irq[p])
        );
    end

    assign irq_out = cell_irq[NUM_IRQ-1:0];

    if (NUM_IRQ < NUM_PINS) begin : g_spare
        logic unused_irq_hi;
        assign unused_irq_hi = |cell_irq[NUM_PINS-1:NUM_IRQ];
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_sel && !bus_wr && kind == WIN_PIN) begin
            bus_rdata = bytes[pin_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            misuse_q <= 1'b0;
        end else if (|misuse_v) begin
            misuse_q <= 1'b1;
        end
    end

    assign misuse_flag = misuse_q;

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
    parameter int ADDR_W      = 6,
    parameter int LEVEL_BYTES = 8,
    parameter int NUM_PINS    = 36,
    parameter int NUM_IRQ     = 10,
    parameter int LVL_PIN     = 1,
    parameter int PULSE_PIN   = 9
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_rdata,
    input logic [NUM_PINS-1:0] pin_upd,
    input logic [NUM_PINS-1:0] pin_val,
    input logic                nmi_req,
    input logic [NUM_IRQ-1:0]  irq_out,
    input logic                misuse_flag
);
    localparam logic [NUM_IRQ-1:0] QUIET_MASK =
        ~((NUM_IRQ'(1) << LVL_PIN) | (NUM_IRQ'(1) << PULSE_PIN));

    // R10
    quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out & QUIET_MASK) == '0);

    // R9
    nmi_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_out[PULSE_PIN]) && $past(nmi_req)) |=> !irq_out[PULSE_PIN]);

    // R8
    pulse_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out[PULSE_PIN]) |-> $past(nmi_req || (pin_upd[PULSE_PIN] && pin_val[PULSE_PIN])));

    // R12
    level_moves_on_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_out[LVL_PIN]) |-> $past(pin_upd[LVL_PIN]));

    // R7
    level_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out[LVL_PIN]) |-> $past(!pin_val[LVL_PIN]));

    // R7
    level_fall_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out[LVL_PIN]) |-> $past(pin_val[LVL_PIN]));

    // R11
    misuse_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        misuse_flag |=> misuse_flag);

    // R3
    level_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr < ADDR_W'(LEVEL_BYTES)) |-> bus_rdata == 8'h00);

    // R5
    outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr >= ADDR_W'(LEVEL_BYTES + NUM_PINS)) |-> bus_rdata == 8'h00);

endmodule

bind gpio_regblock gpio_regblock_chk #(
    .ADDR_W      (ADDR_W),
    .LEVEL_BYTES (LEVEL_BYTES),
    .NUM_PINS    (NUM_PINS),
    .NUM_IRQ     (NUM_IRQ),
    .LVL_PIN     (LVL_PIN),
    .PULSE_PIN   (PULSE_PIN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .pin_upd     (pin_upd),
    .pin_val     (pin_val),
    .nmi_req     (nmi_req),
    .irq_out     (irq_out),
    .misuse_flag (misuse_flag)
);

// File: tb/gpio_regblock_test.sv
module gpio_regblock_test;
    localparam int NP = 36;
    localparam int NI = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pin_upd = '0;
    logic [NP-1:0] pin_val = '0;
    logic          nmi_req = 1'b0;
    logic [NI-1:0] irq_out;
    logic          misuse_flag;

    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    logic [7:0] model [NP];

    always #5 clk = ~clk;

    gpio_regblock uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_upd(pin_upd), .pin_val(pin_val), .nmi_req(nmi_req),
        .irq_out(irq_out), .misuse_flag(misuse_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model_write(input int p, input logic [7:0] d);
        model[p] = {d[7:2], (d[2] ? d[0] : model[p][1]), d[0]};
    endfunction

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a >= 8 && a < 8 + NP) model_write(a - 8, d);
    endtask

    task automatic bus_read(input string req, input int a, input logic [7:0] e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[5:0];
        #1;
        check(req, {24'b0, bus_rdata}, {24'b0, e});
        bus_sel = 1'b0;
    endtask

    task automatic pin_update(input int p, input bit v);
        @(negedge clk);
        pin_upd[p] = 1'b1; pin_val[p] = v;
        @(negedge clk);
        pin_upd[p] = 1'b0;
        model[p][1] = v;
        #1;
    endtask

    task automatic check_all_pins(input string req);
        for (int p = 0; p < NP; p++) bus_read(req, 8 + p, model[p]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < NP; p++) model[p] = (p == 1) ? 8'h02 : 8'h00;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: reset image across the whole address space
        for (int a = 0; a < 64; a++) bus_read("R1", a, (a == 9) ? 8'h02 : 8'h00);
        check("R1 irq", {22'b0, irq_out}, 32'h0);
        check("R1 misuse", {31'b0, misuse_flag}, 32'h0);

        // R2 R4: every byte value into every pin, read back at offset 8+p
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 256; v++) begin
                bus_write(8 + p, v[7:0]);
                bus_read("R2", 8 + p, model[p]);
            end
        end
        // R12: sampled bits moved by writes, interrupt lines did not
        check("R12", {22'b0, irq_out}, 32'h0);

        // R3: level bank ignores writes and reads zero
        for (int a = 0; a < 8; a++) bus_write(a, 8'hFF);
        for (int a = 0; a < 8; a++) bus_read("R3", a, 8'h00);
        check_all_pins("R3");

        // R5: offsets past the pin range
        for (int a = 44; a < 64; a++) bus_write(a, 8'hA5);
        for (int a = 44; a < 64; a++) bus_read("R5", a, 8'h00);
        check_all_pins("R5");

        // clear all pins: drive 0 then release
        for (int p = 0; p < NP; p++) begin
            bus_write(8 + p, 8'h04);
            bus_write(8 + p, 8'h00);
        end
        check_all_pins("R2 clear");
        check("R12 clear", {22'b0, irq_out}, 32'h0);

        // R6: pin 1 already low, low update is no change
        pin_update(1, 1'b0);
        check("R6 nochange", {31'b0, irq_out[1]}, 32'h0);
        pin_update(1, 1'b1);
        check("R7 high", {31'b0, irq_out[1]}, 32'h0);
        bus_read("R6", 9, 8'h02);
        pin_update(1, 1'b0);
        check("R7 assert", {31'b0, irq_out[1]}, 32'h1);
        pin_update(1, 1'b0);
        check("R7 hold", {31'b0, irq_out[1]}, 32'h1);
        pin_update(1, 1'b1);
        check("R7 deassert", {31'b0, irq_out[1]}, 32'h0);

        // R6: only bit 1 replaced
        bus_write(8 + 5, 8'h39);
        pin_update(5, 1'b1);
        bus_read("R6 bits", 13, 8'h3B);

        // R8
        pin_update(9, 1'b1);
        check("R8 assert", {31'b0, irq_out[9]}, 32'h1);
        bus_read("R8", 17, 8'h02);
        pin_update(9, 1'b0);
        check("R8 deassert", {31'b0, irq_out[9]}, 32'h0);

        // R9: one-cycle NMI pulse
        begin
            int high_cycles;
            high_cycles = 0;
            @(negedge clk);
            nmi_req = 1'b1;
            @(negedge clk);
            nmi_req = 1'b0;
            #1;
            check("R9 first", {31'b0, irq_out[9]}, 32'h1);
            for (int c = 0; c < 4; c++) begin
                if (irq_out[9]) high_cycles++;
                @(negedge clk);
                #1;
            end
            check("R9 width", high_cycles, 1);
            check("R9 after", {31'b0, irq_out[9]}, 32'h0);
            bus_read("R9 byte", 17, 8'h00);
        end

        // R10: toggle every other pin, quiet lines stay low
        for (int p = 0; p < NP; p++) begin
            if (p != 1 && p != 9) begin
                pin_update(p, 1'b1);
                check("R10", {22'b0, irq_out & 10'b01_1111_1101}, 32'h0);
                pin_update(p, 1'b0);
                check("R10", {22'b0, irq_out & 10'b01_1111_1101}, 32'h0);
            end
        end
        check_all_pins("R6 sweep");
        check("R11 clean", {31'b0, misuse_flag}, 32'h0);

        // R11: update on a driving pin is applied and flagged
        bus_write(8 + 20, 8'h05);
        bus_read("R11 drive", 28, 8'h07);
        pin_update(20, 1'b0);
        bus_read("R11 applied", 28, 8'h05);
        check("R11 set", {31'b0, misuse_flag}, 32'h1);
        repeat (3) @(negedge clk);
        check("R11 sticky", {31'b0, misuse_flag}, 32'h1);

        // R13: write and update in the same cycle
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'd11; bus_wdata = 8'h04;
        pin_upd[3] = 1'b1; pin_val[3] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; pin_upd[3] = 1'b0;
        bus_read("R13", 11, 8'h06);

        // R1: reset again restores the image
        do_reset();
        bus_read("R1 again", 9, 8'h02);
        bus_read("R1 again", 28, 8'h00);
        bus_read("R1 again", 13, 8'h00);
        check("R1 again irq", {22'b0, irq_out}, 32'h0);
        check("R1 again misuse", {31'b0, misuse_flag}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule